// File: doc/BRIEF.md
# Zoned Secure Backup Register Bank

This block holds a bank of 32-bit backup registers reached through a simple single-request memory-mapped bus. Every request carries a secure attribute and a privileged attribute. Two start indices, held in a security configuration word, cut the bank into three contiguous protection zones. A requester's rights on a register depend on the zone that register lands in and on the request's attributes.

A privilege configuration word can additionally restrict backup access to privileged requesters. A read-only hardware word reports how many backup registers are built. A status word holds a sticky flag that records any refused access. Every request gets a response exactly one cycle later, whether or not it is granted. A refused read returns zero and flags an error. A refused write is dropped.

Top module: `secure_backup_bank`

## Requirements
- R1: After reset the security and privilege configuration words read as zero, the status word reads zero, every backup register reads zero, and the hardware word at byte address 0x008 reads the number of backup registers in bits 7:0 with all other bits zero.
- R2: Every request with req_valid high produces rsp_valid high in the next cycle, with rsp_rdata and rsp_err valid in that same cycle. rsp_valid is low in any cycle that follows a cycle without a request. The latency is the same for granted and refused requests.
- R3: The security configuration word sits at byte address 0x000. Bits 7:0 give the zone 2 start index Z2, and bits 23:16 give the zone 3 start index Z3. Each start index is clamped to the number of registers N. Backup register i is in zone 3 if i >= min(Z3,N), otherwise in zone 2 if i >= min(Z2,N), and otherwise in zone 1. It follows that Z3 = 0 empties zones 1 and 2, and Z2 = 0 empties zone 1.
- R4: Backup register i sits at byte address 0x100 + 4*i. Secure requests may read and write every zone. A non-secure request is refused in zone 1. In zone 2 a non-secure request may read but not write. In zone 3 non-secure requests may read and write.
- R5: The privilege configuration word sits at byte address 0x004. When its bit 29 is set, every non-privileged backup access is refused. When its bit 30 is set, non-privileged backup writes are refused. These checks apply on top of the zone rights.
- R6: Writes to the security configuration word, the privilege configuration word and the status word are granted only to requests that are both secure and privileged. A refused write leaves the word unchanged. Only bits 31, 23:16 and 7:0 of the security word, bits 30:29 of the privilege word and bit 0 of the status word are stored; all other bits read as zero.
- R7: When bit 31 of the security configuration word is set, non-secure reads of the words at 0x000, 0x004 and 0x00C are refused. The hardware word at 0x008 stays readable by every requester.
- R8: A refused write changes no backup register and no configuration word.
- R9: The status word is at 0x00C. Any refused access sets its bit 0. A granted write with bit 0 set clears it, and a write with bit 0 clear leaves it unchanged.
- R10: The following accesses are refused: a backup index at or above N, any address outside 0x000-0x00F and 0x100-0x1FF, and any write to the hardware word.
- R11: A refused request returns rsp_err high with rsp_rdata zero. Write responses always carry rsp_rdata zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 10 | Byte address, bits 1:0 ignored |
| req_wdata | input | 32 | Write data |
| req_secure | input | 1 | Requester is secure |
| req_priv | input | 1 | Requester is privileged |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 32 | Read data, zero when refused or for writes |
| rsp_err | output | 1 | Request was refused |

## Verification
The interaction that matters most is a boundary or privilege update committing at the same clock edge that the next request is presented. That next request must be judged against the new zones, not the old ones. The bench provokes this by following a configuration write back-to-back with an access to the register at the moved boundary. It does this both in directed cases and in a random mix, and it compares each response against a bench model that applies the update before judging the next request. A refused access and the sticky flag update also share one edge: the flag must read as set on the very next status read.

// File: rtl/sbb_pkg.sv
package sbb_pkg;
    localparam int ADDR_W = 10;
    localparam int DATA_W = 32;
    localparam int IDX_W  = 6;
    localparam int BND_W  = 8;

    localparam logic [IDX_W-1:0] W_SECCFG  = 6'd0;
    localparam logic [IDX_W-1:0] W_PRIVCFG = 6'd1;
    localparam logic [IDX_W-1:0] W_HWCFG   = 6'd2;
    localparam logic [IDX_W-1:0] W_STATUS  = 6'd3;

    typedef enum logic [1:0] {
        ZONE_1 = 2'd1,
        ZONE_2 = 2'd2,
        ZONE_3 = 2'd3
    } zone_e;

    typedef struct packed {
        logic [BND_W-1:0]  z2;
        logic [BND_W-1:0]  z3;
        logic              ctrl_sec;
        logic              bkp_rw_priv;
        logic              bkp_w_priv;
        logic              sticky;
        logic              rsp_valid;
        logic              rsp_err;
        logic [DATA_W-1:0] rsp_rdata;
    } state_t;
endpackage

// File: rtl/bkp_zone_decode.sv
module bkp_zone_decode
    import sbb_pkg::*;
#(
    parameter int NUM_REGS = 32
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [BND_W-1:0] z2_start,
    input  logic [BND_W-1:0] z3_start,
    output zone_e            zone
);
    localparam logic [BND_W-1:0] LIMIT = BND_W'(NUM_REGS);

    logic [BND_W-1:0] b2;
    logic [BND_W-1:0] b3;
    logic [BND_W-1:0] idx_w;

    always_comb begin
        b2    = (z2_start > LIMIT) ? LIMIT : z2_start;
        b3    = (z3_start > LIMIT) ? LIMIT : z3_start;
        idx_w = {{(BND_W-IDX_W){1'b0}}, idx};
        if (idx_w >= b3)      zone = ZONE_3;
        else if (idx_w >= b2) zone = ZONE_2;
        else                  zone = ZONE_1;
    end

    always_comb begin
        if (z3_start == '0) begin
            AST_EMPTY_LOW_ZONES: assert (zone == ZONE_3); // R3
        end
    end
endmodule

// File: rtl/bkp_store.sv
module bkp_store
    import sbb_pkg::*;
#(
    parameter int NUM_REGS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(NUM_REGS);

    logic [DATA_W-1:0] mem_d [NUM_REGS];
    logic [DATA_W-1:0] mem_q [NUM_REGS];
    logic              in_range;

    always_comb begin
        in_range = {1'b0, idx} < LIMIT;
        for (int i = 0; i < NUM_REGS; i++) begin
            mem_d[i] = mem_q[i];
            if (wr_en && in_range && (idx == IDX_W'(i))) mem_d[i] = wdata;
        end
        rdata = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (idx == IDX_W'(i)) rdata = mem_q[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) mem_q[i] <= '0;
        end else begin
            for (int i = 0; i < NUM_REGS; i++) mem_q[i] <= mem_d[i];
        end
    end
endmodule

// File: rtl/secure_backup_bank.sv
module secure_backup_bank
    import sbb_pkg::*;
#(
    parameter int NUM_REGS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_secure,
    input  logic              req_priv,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_err
);
    localparam logic [BND_W-1:0] NREG8 = BND_W'(NUM_REGS);

    state_t            st_d, st_q;
    logic [IDX_W-1:0]  word;
    logic              is_ctrl, is_bkp;
    zone_e             zone;
    logic [DATA_W-1:0] store_rdata;
    logic [DATA_W-1:0] ctrl_rdata;
    logic              ctrl_ok, bkp_zone_ok, bkp_priv_ok, granted;
    logic              store_we;

    bkp_zone_decode #(.NUM_REGS(NUM_REGS)) u_zone (
        .idx      (word),
        .z2_start (st_q.z2),
        .z3_start (st_q.z3),
        .zone     (zone)
    );

    bkp_store #(.NUM_REGS(NUM_REGS)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (store_we),
        .idx   (word),
        .wdata (req_wdata),
        .rdata (store_rdata)
    );

    always_comb begin
        word    = req_addr[7:2];
        is_ctrl = (req_addr[9:8] == 2'b00) && (word < 6'd4);
        is_bkp  = (req_addr[9:8] == 2'b01) && ({2'b00, word} < NREG8);

        // control word permissions
        if (req_write) ctrl_ok = req_secure && req_priv && (word != W_HWCFG);
        else           ctrl_ok = (word == W_HWCFG) || req_secure || !st_q.ctrl_sec;

        // backup permissions: zone rights then privilege restrictions
        bkp_zone_ok = req_secure || (zone == ZONE_3) || ((zone == ZONE_2) && !req_write);
        bkp_priv_ok = req_priv || (!st_q.bkp_rw_priv && !(req_write && st_q.bkp_w_priv));

        granted = is_ctrl ? ctrl_ok : (is_bkp && bkp_zone_ok && bkp_priv_ok);

        case (word)
            W_SECCFG:  ctrl_rdata = {st_q.ctrl_sec, 7'b0, st_q.z3, 8'b0, st_q.z2};
            W_PRIVCFG: ctrl_rdata = {1'b0, st_q.bkp_w_priv, st_q.bkp_rw_priv, 29'b0};
            W_HWCFG:   ctrl_rdata = {24'b0, NREG8};
            default:   ctrl_rdata = {31'b0, st_q.sticky};
        endcase

        store_we = req_valid && req_write && is_bkp && granted;

        st_d           = st_q;
        st_d.rsp_valid = req_valid;
        st_d.rsp_err   = req_valid && !granted;
        st_d.rsp_rdata = '0;
        if (req_valid && granted && !req_write)
            st_d.rsp_rdata = is_ctrl ? ctrl_rdata : store_rdata;

        if (req_valid && granted && req_write && is_ctrl) begin
            case (word)
                W_SECCFG: begin
                    st_d.z2       = req_wdata[7:0];
                    st_d.z3       = req_wdata[23:16];
                    st_d.ctrl_sec = req_wdata[31];
                end
                W_PRIVCFG: begin
                    st_d.bkp_rw_priv = req_wdata[29];
                    st_d.bkp_w_priv  = req_wdata[30];
                end
                W_STATUS: if (req_wdata[0]) st_d.sticky = 1'b0;
                default: ;
            endcase
        end
        if (req_valid && !granted) st_d.sticky = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid = st_q.rsp_valid;
    assign rsp_err   = st_q.rsp_err;
    assign rsp_rdata = st_q.rsp_rdata;

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R2
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R2
    AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_valid && rsp_rdata == '0)); // R11
    AST_ERR_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> st_q.sticky); // R9
    AST_NS_ZONE1_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && is_bkp && !req_secure && zone == ZONE_1) |=> rsp_err); // R4
    AST_CFG_WRITE_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !(req_secure && req_priv)) |=>
            ($stable(st_q.z2) && $stable(st_q.z3) && $stable(st_q.ctrl_sec)
             && $stable(st_q.bkp_rw_priv) && $stable(st_q.bkp_w_priv))); // R6
endmodule

// File: tb/sim_secure_backup_bank.sv
module sim_secure_backup_bank;
    localparam int N = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_secure = 1'b0, req_priv = 1'b0;
    logic [9:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid, rsp_err;
    logic [31:0] rsp_rdata;

    int checks = 0, errors = 0, cycles = 0;
    bit done = 0;

    // bench model
    logic [31:0] m_mem [N];
    logic [7:0]  m_z2, m_z3;
    bit          m_csec, m_rwp, m_wp, m_sticky;

    always #5 clk = ~clk;

    secure_backup_bank #(.NUM_REGS(N)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_secure(req_secure),
        .req_priv(req_priv), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err)
    );

    function automatic int zone_of(int i);
        int b2 = (m_z2 > N) ? N : int'(m_z2);
        int b3 = (m_z3 > N) ? N : int'(m_z3);
        if (i >= b3) return 3;
        if (i >= b2) return 2;
        return 1;
    endfunction

    function automatic bit allowed(bit w, logic [9:0] a, bit s, bit p);
        int wd = int'(a[7:2]);
        int z;
        if (a[9:8] == 2'b00 && wd < 4) begin
            if (w) return s && p && wd != 2;
            return wd == 2 || s || !m_csec;
        end
        if (a[9:8] != 2'b01 || wd >= N) return 0;
        z = zone_of(wd);
        if (!p && (m_rwp || (w && m_wp))) return 0;
        return s || z == 3 || (z == 2 && !w);
    endfunction

    function automatic logic [31:0] read_val(logic [9:0] a);
        int wd = int'(a[7:2]);
        if (a[9:8] == 2'b01) return m_mem[wd];
        case (wd)
            0: return {m_csec, 7'b0, m_z3, 8'b0, m_z2};
            1: return {1'b0, m_wp, m_rwp, 29'b0};
            2: return 32'(N);
            default: return {31'b0, m_sticky};
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic access(bit w, logic [9:0] a, logic [31:0] d, bit s, bit p, string tag);
        bit ok = allowed(w, a, s, p);
        logic [31:0] er = (ok && !w) ? read_val(a) : 32'h0;
        req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
        req_secure = s; req_priv = p;
        @(negedge clk);
        req_valid = 0;
        chk({tag, " R2 valid"}, 32'(rsp_valid), 32'h1);
        chk({tag, " err"}, 32'(rsp_err), 32'(!ok));
        chk({tag, " R11 rdata"}, rsp_rdata, er);
        if (ok && w) begin
            if (a[9:8] == 2'b01) m_mem[a[7:2]] = d;
            else case (int'(a[7:2]))
                0: begin m_z2 = d[7:0]; m_z3 = d[23:16]; m_csec = d[31]; end
                1: begin m_rwp = d[29]; m_wp = d[30]; end
                3: if (d[0]) m_sticky = 0;
                default: ;
            endcase
        end
        if (!ok) m_sticky = 1;
    endtask

    function automatic logic [9:0] bkp(int i);
        return 10'(10'h100 + 4*i);
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            errors++;
            $display("FAIL watchdog R2 actual hung expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) m_mem[i] = 0;
        m_z2 = 0; m_z3 = 0; m_csec = 0; m_rwp = 0; m_wp = 0; m_sticky = 0;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 idle rsp_valid R2", 32'(rsp_valid), 0);
        // R1 reset state
        access(0, 10'h000, 0, 1, 1, "R1 seccfg");
        access(0, 10'h004, 0, 1, 1, "R1 privcfg");
        access(0, 10'h00C, 0, 1, 1, "R1 status");
        access(0, 10'h008, 0, 0, 0, "R1 hwcfg R7");
        access(0, bkp(N-1), 0, 0, 0, "R1 bkp zone3 open");
        // R3/R4 zones: Z2=4 Z3=8
        access(1, 10'h000, 32'h0008_0004, 1, 1, "R3 set zones");
        access(0, bkp(3), 0, 0, 1, "R4 ns zone1 read");
        access(1, bkp(2), 32'hA5A5_0002, 1, 0, "R4 sec zone1 write");
        access(0, bkp(2), 0, 1, 0, "R4 sec zone1 read");
        access(0, bkp(4), 0, 0, 1, "R3 ns zone2 first read");
        access(1, bkp(5), 32'h1111_0005, 0, 1, "R8 ns zone2 write");
        access(0, bkp(5), 0, 1, 1, "R8 zone2 unchanged");
        access(1, bkp(8), 32'h2222_0008, 0, 0, "R4 ns zone3 write");
        access(0, bkp(8), 0, 0, 0, "R4 ns zone3 read");
        access(0, bkp(7), 0, 0, 0, "R3 zone2 last ns read");
        // clamp and empty zones
        access(1, 10'h000, 32'h0050_0040, 1, 1, "R3 oversize bounds");
        access(0, bkp(N-1), 0, 0, 1, "R3 clamped all zone1");
        access(1, 10'h000, 32'h0000_0010, 1, 1, "R3 z3 zero");
        access(0, bkp(0), 0, 0, 0, "R3 all zone3");
        // privilege word
        access(1, 10'h004, 32'h2000_0000, 1, 1, "R5 set rw priv");
        access(0, bkp(1), 0, 1, 0, "R5 nonpriv read");
        access(1, 10'h004, 32'h4000_0000, 1, 1, "R5 set w priv");
        access(0, bkp(1), 0, 1, 0, "R5 nonpriv read ok");
        access(1, bkp(1), 32'h33, 1, 0, "R5 nonpriv write");
        access(1, 10'h004, 32'h0, 1, 1, "R5 clear");
        // control guard
        access(1, 10'h000, 32'hFFFF_FFFF, 0, 1, "R6 ns cfg write");
        access(1, 10'h000, 32'hFFFF_FFFF, 1, 0, "R6 nonpriv cfg write");
        access(0, 10'h000, 0, 1, 1, "R6 cfg unchanged");
        access(1, 10'h000, 32'h8000_0000, 1, 1, "R7 set ctrl secure");
        access(0, 10'h000, 0, 0, 1, "R7 ns cfg read");
        access(0, 10'h00C, 0, 0, 1, "R7 ns status read");
        access(0, 10'h008, 0, 0, 0, "R7 ns hw read");
        // R10
        access(0, bkp(N + 2), 0, 1, 1, "R10 out of range");
        access(0, 10'h010, 0, 1, 1, "R10 unmapped");
        access(1, 10'h008, 32'h7, 1, 1, "R10 hw write");
        // R9 sticky
        access(0, 10'h00C, 0, 1, 1, "R9 sticky set");
        access(1, 10'h00C, 32'h0, 1, 1, "R9 write 0");
        access(0, 10'h00C, 0, 1, 1, "R9 still set");
        access(1, 10'h00C, 32'h1, 1, 1, "R9 w1c");
        access(0, 10'h00C, 0, 1, 1, "R9 cleared");
        access(1, 10'h000, 32'h0, 1, 1, "R6 restore");
        // random mix with back-to-back boundary updates
        for (int k = 0; k < 1500; k++) begin
            int sel = int'($urandom % 10);
            logic [9:0] a;
            logic [31:0] d = $urandom;
            bit w = $urandom % 2;
            bit s = $urandom % 2;
            bit p = $urandom % 2;
            if (sel < 2) begin
                a = 10'(($urandom % 4) * 4);
                if (a == 10'h000) begin
                    d = {($urandom % 8) == 0, 7'b0, 8'($urandom % 40), 8'b0, 8'($urandom % 40)};
                    if ($urandom % 2) begin s = 1; p = 1; end
                end
            end else if (sel < 9) a = bkp(int'($urandom % 36));
            else a = 10'(10'h200 + ($urandom % 64) * 4);
            access(w, a, d, s, p, "R4 random");
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule